// File: doc/BRIEF.md
# Bit-Band Alias Translator

This block sits between a bus master and a byte-addressed backing memory and gives the master a bit-level view of part of that memory. Two alias windows, each 32 MB wide, are decoded from the request address. Every word-aligned alias address in a window stands for one bit of a 1 MB target region. A read of an alias word returns that single bit in bit 0. A write of an alias word sets or clears that one bit, leaving its neighbours unchanged.

Each alias access is turned into a sequence on the backing port. A read becomes one backing read. A write becomes a read followed by a merged write-back at the same address and size. The block handles one transaction at a time: a request is accepted only while `s_ready` is high, and the block stays busy until it has returned a one-cycle response with read data and an error flag. Requests of an unsupported size, or to addresses outside both windows, are answered with an error and never reach the backing memory.

Top module: `bitband_xlate`

## Requirements
- R1: Window 0 covers alias addresses 0x22000000 to 0x23FFFFFF and maps them to target base 0x20000000. Window 1 covers 0x42000000 to 0x43FFFFFF and maps them to target base 0x40000000. Any other address gets a response with `s_err`=1 and `s_rdata`=0, and no backing strobe is issued.
- R2: The backing address is the window's target base ORed with alias address bits [24:5] placed at bits [19:0]. It is then rounded down to a multiple of the access size.
- R3: Sizes are encoded on `s_size` and `m_size` as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Code 3 is rejected with `s_err`=1 and no backing strobe. The backing access uses the request's size code.
- R4: Backing data is little-endian and right-justified on `m_rdata`/`m_wdata`: byte k of the access sits at bits [8k+7:8k]. The selected bit index is alias address bits [6:2] masked to (8 × size in bytes − 1). This is bit [4:2] for bytes, [5:2] for halfwords and [6:2] for words.
- R5: An alias read issues exactly one backing read. It returns the selected bit in `s_rdata[0]`, with `s_rdata[31:1]`=0 and `s_err`=0.
- R6: An alias write first reads the target. It then writes back, at the same address and size, the fetched data with only the selected bit replaced by `s_wdata[0]`. The response carries `s_err`=0 and `s_rdata`=0.
- R7: If the backing read of a write reports `m_err`, the response carries `s_err`=1 and no write-back is issued.
- R8: If the backing write reports `m_err`, the response carries `s_err`=1.
- R9: `s_ready` is low from the cycle after a request is accepted up to and including the response cycle. `s_rsp_valid` is high for exactly one cycle per accepted request.
- R10: `m_rd` and `m_wr` are one-cycle strobes that are never high together. No new strobe is issued until `m_ready` has answered the previous one.
- R11: After reset `s_ready`=1, and `m_rd`, `m_wr` and `s_rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_req | input | 1 | Request; accepted in a cycle where s_ready is high |
| s_addr | input | 32 | Alias byte address |
| s_size | input | 2 | Access size code (0/1/2 = 1/2/4 bytes) |
| s_we | input | 1 | 1 = alias write, 0 = alias read |
| s_wdata | input | 32 | Write data; only bit 0 is used |
| s_ready | output | 1 | Idle and able to accept a request |
| s_rsp_valid | output | 1 | One-cycle response strobe |
| s_rdata | output | 32 | Read result (selected bit in bit 0) |
| s_err | output | 1 | Error flag, valid with s_rsp_valid |
| m_rd | output | 1 | Backing read strobe |
| m_wr | output | 1 | Backing write strobe |
| m_addr | output | 32 | Backing byte address |
| m_size | output | 2 | Backing size code |
| m_wdata | output | 32 | Backing write data, right-justified |
| m_ready | input | 1 | Backing completion pulse |
| m_rdata | input | 32 | Backing read data, valid with m_ready |
| m_err | input | 1 | Backing error, valid with m_ready |

## Verification
The checker assumes that the backing memory raises `m_ready` only once for each strobe, and only while that strobe is outstanding. It also assumes that `m_rdata` and `m_err` matter only in that completion cycle. The bench memory model keeps to this: it counts strobes, answers each one exactly once after a programmable latency, and drives `m_ready` low at every other edge. On the slave side, requests are raised only when `s_ready` is high and are dropped one cycle later. The write-back address rule therefore holds for every transaction the bench sends, as do the rule that no write follows a failed read and the rule that responses return only bit 0.

// File: rtl/bbx_pkg.sv
package bbx_pkg;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BIDX_W = $clog2(DW);

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_RESP
    } bbx_state_e;

    typedef struct packed {
        logic [AW-1:0]     taddr;
        logic [1:0]        size;
        logic [BIDX_W-1:0] bidx;
        logic              we;
        logic              wbit;
    } bbx_txn_t;

    function automatic logic size_legal(logic [1:0] sz);
        return sz != 2'd3;
    endfunction

    function automatic logic [DW-1:0] lane_mask(logic [1:0] sz);
        case (sz)
            SZ_BYTE: return DW'(32'h0000_00FF);
            SZ_HALF: return DW'(32'h0000_FFFF);
            default: return {DW{1'b1}};
        endcase
    endfunction

    function automatic logic [BIDX_W-1:0] idx_mask(logic [1:0] sz);
        case (sz)
            SZ_BYTE: return BIDX_W'(7);
            SZ_HALF: return BIDX_W'(15);
            default: return BIDX_W'(31);
        endcase
    endfunction

    function automatic logic [AW-1:0] align_down(logic [AW-1:0] a, logic [1:0] sz);
        case (sz)
            SZ_BYTE: return a;
            SZ_HALF: return {a[AW-1:1], 1'b0};
            default: return {a[AW-1:2], 2'b00};
        endcase
    endfunction

endpackage

// File: rtl/bbx_decode.sv
module bbx_decode
    import bbx_pkg::*;
#(
    parameter int NWIN = 2,
    parameter int WIN_BITS = 25,
    parameter logic [NWIN-1:0][AW-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NWIN-1:0][AW-1:0] TARGET_BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic          we,
    input  logic          wbit,
    output logic          hit,
    output bbx_txn_t      txn
);
    localparam int TOFF_W = WIN_BITS - 5;

    logic [NWIN-1:0]          win_hit;
    logic [NWIN-1:0][AW-1:0]  win_tgt;
    logic [AW-1:0]            raw_tgt;
    logic                     unused_lo;

    assign unused_lo = ^addr[1:0];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign win_hit[w] = (addr[AW-1:WIN_BITS] == ALIAS_BASES[w][AW-1:WIN_BITS]);
        assign win_tgt[w] = TARGET_BASES[w] | AW'(addr[WIN_BITS-1:5]);
    end

    // lowest-numbered window wins if two were ever configured to overlap
    always_comb begin
        hit     = 1'b0;
        raw_tgt = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (win_hit[w]) begin
                hit     = 1'b1;
                raw_tgt = win_tgt[w];
            end
        end
    end

    always_comb begin
        txn.taddr = align_down(raw_tgt, size);
        txn.size  = size;
        txn.bidx  = addr[BIDX_W+1:2] & idx_mask(size);
        txn.we    = we;
        txn.wbit  = wbit;
    end

    initial begin
        if (TOFF_W < 1) $error("WIN_BITS too small");
    end

endmodule

// File: rtl/bbx_bitop.sv
module bbx_bitop
    import bbx_pkg::*;
(
    input  logic [DW-1:0]     rdata,
    input  logic [1:0]        size,
    input  logic [BIDX_W-1:0] bidx,
    input  logic              wbit,
    output logic              rbit,
    output logic [DW-1:0]     merged
);
    logic [DW-1:0] lanes;
    logic [DW-1:0] sel;

    always_comb begin
        lanes  = rdata & lane_mask(size);
        sel    = DW'(1) << bidx;
        rbit   = |(lanes & sel);
        merged = wbit ? (lanes | sel) : (lanes & ~sel);
    end

endmodule

// File: rtl/bbx_seq.sv
module bbx_seq
    import bbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          s_req,
    input  logic          req_hit,
    input  bbx_txn_t      req_txn,
    input  logic          m_ready,
    input  logic          m_err,
    input  logic          rbit,
    input  logic [DW-1:0] merged,
    output logic          s_ready,
    output logic          s_rsp_valid,
    output logic [DW-1:0] s_rdata,
    output logic          s_err,
    output logic          m_rd,
    output logic          m_wr,
    output bbx_txn_t      txn_q,
    output logic [DW-1:0] m_wdata
);
    bbx_state_e    state;
    logic [DW-1:0] wdata_q;
    logic          rbit_q;
    logic          err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            txn_q   <= '0;
            wdata_q <= '0;
            rbit_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (s_req) begin
                        txn_q  <= req_txn;
                        rbit_q <= 1'b0;
                        err_q  <= 1'b0;
                        if (req_hit && size_legal(req_txn.size)) begin
                            state <= ST_RD_REQ;
                        end else begin
                            err_q <= 1'b1;
                            state <= ST_RESP;
                        end
                    end
                end
                ST_RD_REQ: state <= ST_RD_WAIT;
                ST_RD_WAIT: begin
                    if (m_ready) begin
                        if (m_err) begin
                            err_q <= 1'b1;
                            state <= ST_RESP;
                        end else if (txn_q.we) begin
                            wdata_q <= merged;
                            state   <= ST_WR_REQ;
                        end else begin
                            rbit_q <= rbit;
                            state  <= ST_RESP;
                        end
                    end
                end
                ST_WR_REQ: state <= ST_WR_WAIT;
                ST_WR_WAIT: begin
                    if (m_ready) begin
                        err_q <= m_err;
                        state <= ST_RESP;
                    end
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign s_ready     = (state == ST_IDLE);
    assign s_rsp_valid = (state == ST_RESP);
    assign s_rdata     = {{(DW-1){1'b0}}, rbit_q};
    assign s_err       = err_q;
    assign m_rd        = (state == ST_RD_REQ);
    assign m_wr        = (state == ST_WR_REQ);
    assign m_wdata     = wdata_q;

endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
    import bbx_pkg::*;
#(
    parameter int NWIN = 2,
    parameter int WIN_BITS = 25,
    parameter logic [NWIN-1:0][AW-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NWIN-1:0][AW-1:0] TARGET_BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s_req,
    input  logic [AW-1:0] s_addr,
    input  logic [1:0]    s_size,
    input  logic          s_we,
    input  logic [DW-1:0] s_wdata,
    output logic          s_ready,
    output logic          s_rsp_valid,
    output logic [DW-1:0] s_rdata,
    output logic          s_err,
    output logic          m_rd,
    output logic          m_wr,
    output logic [AW-1:0] m_addr,
    output logic [1:0]    m_size,
    output logic [DW-1:0] m_wdata,
    input  logic          m_ready,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_err
);
    logic          req_hit;
    bbx_txn_t      req_txn;
    bbx_txn_t      txn_q;
    logic          rbit;
    logic [DW-1:0] merged;
    logic          unused_wdata;

    assign unused_wdata = ^s_wdata[DW-1:1];

    bbx_decode #(
        .NWIN(NWIN),
        .WIN_BITS(WIN_BITS),
        .ALIAS_BASES(ALIAS_BASES),
        .TARGET_BASES(TARGET_BASES)
    ) u_decode (
        .addr(s_addr),
        .size(s_size),
        .we(s_we),
        .wbit(s_wdata[0]),
        .hit(req_hit),
        .txn(req_txn)
    );

    bbx_bitop u_bitop (
        .rdata(m_rdata),
        .size(txn_q.size),
        .bidx(txn_q.bidx),
        .wbit(txn_q.wbit),
        .rbit(rbit),
        .merged(merged)
    );

    bbx_seq u_seq (
        .clk(clk),
        .rst(rst),
        .s_req(s_req),
        .req_hit(req_hit),
        .req_txn(req_txn),
        .m_ready(m_ready),
        .m_err(m_err),
        .rbit(rbit),
        .merged(merged),
        .s_ready(s_ready),
        .s_rsp_valid(s_rsp_valid),
        .s_rdata(s_rdata),
        .s_err(s_err),
        .m_rd(m_rd),
        .m_wr(m_wr),
        .txn_q(txn_q),
        .m_wdata(m_wdata)
    );

    assign m_addr = txn_q.taddr;
    assign m_size = txn_q.size;

endmodule

// File: rtl/bbx_check.sv
module bbx_check (
    input logic        clk,
    input logic        rst,
    input logic        s_req,
    input logic [1:0]  s_size,
    input logic        s_ready,
    input logic        s_rsp_valid,
    input logic [30:0] s_rdata_hi,
    input logic        s_err,
    input logic        m_rd,
    input logic        m_wr,
    input logic [31:0] m_addr,
    input logic [1:0]  m_size,
    input logic        m_ready,
    input logic        m_err
);
    logic        pend_q;
    logic        rd_pend_q;
    logic        rd_err_q;
    logic [31:0] rd_addr_q;
    logic [1:0]  rd_size_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            rd_pend_q <= 1'b0;
            rd_err_q  <= 1'b0;
            rd_addr_q <= '0;
            rd_size_q <= '0;
        end else begin
            if (m_rd || m_wr) pend_q <= 1'b1;
            else if (m_ready) pend_q <= 1'b0;
            if (m_rd) rd_pend_q <= 1'b1;
            else if (m_ready) rd_pend_q <= 1'b0;
            if (m_rd) begin
                rd_addr_q <= m_addr;
                rd_size_q <= m_size;
            end
            if (s_req && s_ready) rd_err_q <= 1'b0;
            else if (rd_pend_q && m_ready && m_err) rd_err_q <= 1'b1;
        end
    end

    assert_reset_state_R11: assert property (@(posedge clk)
        rst |=> (s_ready && !m_rd && !m_wr && !s_rsp_valid));

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(m_rd && m_wr));

    assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        m_rd |=> !m_rd);

    assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        m_wr |=> !m_wr);

    assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (rst)
        (m_rd || m_wr) |-> !pend_q);

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        s_rsp_valid |=> !s_rsp_valid);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (s_req && s_ready) |=> !s_ready);

    assert_busy_on_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        s_rsp_valid |-> !s_ready);

    assert_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        (m_rd || m_wr) |-> ((m_size == 2'd2) ? (m_addr[1:0] == 2'b00)
                          : (m_size == 2'd1) ? !m_addr[0] : 1'b1));

    assert_legal_size_R3: assert property (@(posedge clk) disable iff (rst)
        (m_rd || m_wr) |-> (m_size != 2'd3));

    assert_bad_size_R3: assert property (@(posedge clk) disable iff (rst)
        (s_req && s_ready && s_size == 2'd3) |=> (s_rsp_valid && s_err && !m_rd));

    assert_rdata_bit0_R5: assert property (@(posedge clk) disable iff (rst)
        s_rsp_valid |-> (s_rdata_hi == '0));

    assert_wb_same_addr_R6: assert property (@(posedge clk) disable iff (rst)
        m_wr |-> (m_addr == rd_addr_q && m_size == rd_size_q));

    assert_no_wb_after_err_R7: assert property (@(posedge clk) disable iff (rst)
        m_wr |-> !rd_err_q);

endmodule

bind bitband_xlate bbx_check u_bbx_check (
    .clk(clk),
    .rst(rst),
    .s_req(s_req),
    .s_size(s_size),
    .s_ready(s_ready),
    .s_rsp_valid(s_rsp_valid),
    .s_rdata_hi(s_rdata[31:1]),
    .s_err(s_err),
    .m_rd(m_rd),
    .m_wr(m_wr),
    .m_addr(m_addr),
    .m_size(m_size),
    .m_ready(m_ready),
    .m_err(m_err)
);

// File: tb/sim_bitband_xlate.sv
module sim_bitband_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_req = 1'b0;
    logic [31:0] s_addr = '0;
    logic [1:0]  s_size = '0;
    logic        s_we = 1'b0;
    logic [31:0] s_wdata = '0;
    logic        s_ready, s_rsp_valid, s_err;
    logic [31:0] s_rdata;
    logic        m_rd, m_wr;
    logic [31:0] m_addr, m_wdata;
    logic [1:0]  m_size;
    logic        m_ready = 1'b0;
    logic [31:0] m_rdata = '0;
    logic        m_err = 1'b0;

    always #2 clk = ~clk;

    bitband_xlate u0 (
        .clk(clk), .rst(rst),
        .s_req(s_req), .s_addr(s_addr), .s_size(s_size), .s_we(s_we), .s_wdata(s_wdata),
        .s_ready(s_ready), .s_rsp_valid(s_rsp_valid), .s_rdata(s_rdata), .s_err(s_err),
        .m_rd(m_rd), .m_wr(m_wr), .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
        .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- backing memory model ----------------
    logic [7:0]  mem [4096];
    int          lat = 0;
    bit          rd_err_en = 0, wr_err_en = 0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [31:0] last_rd_addr = '0, last_wr_addr = '0, last_wr_data = '0;
    logic [1:0]  last_rd_size = '0, last_wr_size = '0;
    bit          pend = 0, pend_wr = 0;
    int          cnt = 0;
    logic [31:0] p_addr, p_data;
    logic [1:0]  p_size;

    function automatic int midx(input logic [31:0] a);
        return int'({a[30], a[10:0]});
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] v = '0;
        for (int b = 0; b < (1 << sz); b++) v[8*b +: 8] = mem[midx(a + 32'(b))];
        return v;
    endfunction

    always @(posedge clk) begin
        m_ready <= 1'b0;
        m_err   <= 1'b0;
        if (rst) begin
            pend = 0;
        end else begin
            if (m_rd || m_wr) begin
                pend = 1; pend_wr = m_wr; cnt = lat;
                p_addr = m_addr; p_size = m_size; p_data = m_wdata;
                if (m_rd) begin
                    rd_cnt++; last_rd_addr = m_addr; last_rd_size = m_size;
                end else begin
                    wr_cnt++; last_wr_addr = m_addr; last_wr_size = m_size; last_wr_data = m_wdata;
                end
            end
            if (pend && cnt == 0) begin
                pend = 0;
                m_ready <= 1'b1;
                if (pend_wr) begin
                    m_err <= wr_err_en;
                    if (!wr_err_en)
                        for (int b = 0; b < (1 << p_size); b++)
                            mem[midx(p_addr + 32'(b))] = p_data[8*b +: 8];
                end else begin
                    m_err   <= rd_err_en;
                    m_rdata <= mem_word(p_addr, p_size);
                end
            end else if (pend) begin
                cnt--;
            end
        end
    end

    // ---------------- expected-value helpers ----------------
    function automatic logic [31:0] e_taddr(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] base = a[30] ? 32'h4000_0000 : 32'h2000_0000;
        logic [31:0] t = base | {12'b0, a[24:5]};
        return t & ~((32'd1 << sz) - 32'd1);
    endfunction

    function automatic int e_idx(input logic [31:0] a, input logic [1:0] sz);
        return int'((a >> 2) & ((32'd8 << sz) - 32'd1));
    endfunction

    task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic we,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er);
        @(negedge clk);
        chk("R9 ready before request", 32'(s_ready), 32'd1);
        s_req = 1'b1; s_addr = a; s_size = sz; s_we = we; s_wdata = wd;
        @(negedge clk);
        s_req = 1'b0;
        chk("R9 busy after accept", 32'(s_ready), 32'd0);
        while (!s_rsp_valid) @(negedge clk);
        rd = s_rdata; er = s_err;
        @(negedge clk);
        chk("R9 response one cycle", 32'(s_rsp_valid), 32'd0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R11 ready in reset", 32'(s_ready), 32'd1);
        chk("R11 no read strobe", 32'(m_rd), 32'd0);
        chk("R11 no write strobe", 32'(m_wr), 32'd0);
        chk("R11 no response", 32'(s_rsp_valid), 32'd0);
    endtask

    task automatic t_read(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] rd, tg;
        logic er;
        int r0 = rd_cnt, w0 = wr_cnt;
        tg = e_taddr(a, sz);
        access(a, sz, 1'b0, 32'h0, rd, er);
        chk("R5 read bit", rd, (mem_word(tg, sz) >> e_idx(a, sz)) & 32'd1);
        chk("R5 read no error", 32'(er), 32'd0);
        chk("R2 read target address", last_rd_addr, tg);
        chk("R3 read size passed", 32'(last_rd_size), 32'(sz));
        chk("R5 one backing read", 32'(rd_cnt - r0), 32'd1);
        chk("R5 no backing write", 32'(wr_cnt - w0), 32'd0);
    endtask

    task automatic t_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd);
        logic [31:0] rd, tg, old, exp;
        logic er;
        int w0 = wr_cnt;
        int ix;
        tg  = e_taddr(a, sz);
        ix  = e_idx(a, sz);
        old = mem_word(tg, sz);
        exp = wd[0] ? (old | (32'd1 << ix)) : (old & ~(32'd1 << ix));
        access(a, sz, 1'b1, wd, rd, er);
        chk("R6 write no error", 32'(er), 32'd0);
        chk("R6 write rdata zero", rd, 32'd0);
        chk("R6 one write-back", 32'(wr_cnt - w0), 32'd1);
        chk("R6 write-back address", last_wr_addr, tg);
        chk("R6 write-back size", 32'(last_wr_size), 32'(sz));
        chk("R6 merged data", last_wr_data, exp);
        t_read(a, sz);
    endtask

    task automatic t_reject(input logic [31:0] a, input logic [1:0] sz, input string tag);
        logic [31:0] rd;
        logic er;
        int r0 = rd_cnt, w0 = wr_cnt;
        access(a, sz, 1'b1, 32'h1, rd, er);
        chk({tag, " error flag"}, 32'(er), 32'd1);
        chk({tag, " rdata zero"}, rd, 32'd0);
        chk({tag, " no backing access"}, 32'((rd_cnt - r0) + (wr_cnt - w0)), 32'd0);
    endtask

    task automatic t_rd_err();
        logic [31:0] rd, tg, old;
        logic er;
        int w0 = wr_cnt;
        tg = e_taddr(32'h2200_0104, 2'd0);
        old = mem_word(tg, 2'd0);
        rd_err_en = 1;
        access(32'h2200_0104, 2'd0, 1'b1, ~old, rd, er);
        rd_err_en = 0;
        chk("R7 read error reported", 32'(er), 32'd1);
        chk("R7 no write-back", 32'(wr_cnt - w0), 32'd0);
        chk("R7 memory unchanged", mem_word(tg, 2'd0), old);
    endtask

    task automatic t_wr_err();
        logic [31:0] rd, tg, old;
        logic er;
        int w0 = wr_cnt;
        tg = e_taddr(32'h2200_0208, 2'd1);
        old = mem_word(tg, 2'd1);
        wr_err_en = 1;
        access(32'h2200_0208, 2'd1, 1'b1, 32'h1, rd, er);
        wr_err_en = 0;
        chk("R8 write error reported", 32'(er), 32'd1);
        chk("R8 write attempted", 32'(wr_cnt - w0), 32'd1);
        chk("R8 memory unchanged", mem_word(tg, 2'd1), old);
    endtask

    bit done = 0;

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 29 + (i >> 3) * 7 + 3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        // R1 R2 R4: reads in window 0 at each size and several bit positions
        t_read(32'h2200_0010, 2'd0);
        t_read(32'h2200_001C, 2'd0);
        t_read(32'h2200_003C, 2'd1);
        t_read(32'h2200_0020, 2'd1);
        t_read(32'h2200_007C, 2'd2);
        t_read(32'h2200_1234, 2'd2);
        t_read(32'h2200_4568, 2'd0);
        // R1: window 1
        t_read(32'h4200_0040, 2'd2);
        t_read(32'h4200_0A6C, 2'd1);
        // R6: set and clear at each size
        t_write(32'h2200_0304, 2'd0, 32'h1);
        t_write(32'h2200_0304, 2'd0, 32'hFFFF_FFFE);
        t_write(32'h2200_0538, 2'd1, 32'h3);
        t_write(32'h4200_0660, 2'd2, 32'h0);
        t_write(32'h4200_0660, 2'd2, 32'h1);
        // R10: slower backing memory
        lat = 3;
        t_read(32'h2200_0878, 2'd2);
        t_write(32'h2200_0914, 2'd1, 32'h1);
        lat = 0;
        // R1 R3: rejected requests
        t_reject(32'h2400_0000, 2'd0, "R1 above window 0");
        t_reject(32'h21FF_FFFC, 2'd2, "R1 below window 0");
        t_reject(32'h6200_0000, 2'd0, "R1 unmapped region");
        t_reject(32'h2200_0000, 2'd3, "R3 unsupported size");
        // R7 R8: backing errors
        t_rd_err();
        t_wr_err();
        t_read(32'h2200_0010, 2'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule